// File: doc/BRIEF.md
# Ethernet Frame Trap Classifier

This block watches the head of an incoming Ethernet frame, one byte per clock. It reads from the first destination-address byte through the two bytes that follow the source address. From those bytes it decides where the frame goes: a local extract queue, Ethernet output port 1 or Ethernet output port 2. A frame that carries the programmed tag goes to an external VLAN stage instead.

A 16-bit configuration word holds the settings. Two destination-address traps (reserved management prefix and broadcast) are enabled separately. One bit steers untagged frames to port 1 or port 2. One bit, written as 1, gives a single-clock reset pulse to the extract FIFO. A 16-bit tag identifier input is compared with frame bytes 13 and 14.

The block gives one registered decision strobe per frame. It also keeps a counter of frames that ended too early to be classified.

Top module: `eth_trap_classifier`

## Requirements
- R1: Configuration bit 9 enables the management trap. A frame whose destination bytes 1 to 3 are 01, 80, C2 then gets the extract decision, whatever destination bytes 4 to 6 hold.
- R2: Configuration bit 8 enables the broadcast trap. A frame whose six destination bytes are all FF then gets the extract decision.
- R3: After reset all trap enables, the steering bit and the FIFO reset output are 0, `dec_vld` is 0 and `runt_cnt` is 0.
- R4: The trap enables act independently and in any combination. When any enabled trap hits, the decision is extract only, even if the tag or the steering bit would pick something else.
- R5: If no enabled trap hits and frame bytes 13 and 14 equal `tag_id` (byte 13 is the upper byte), the decision is tagged: `dec_tagged`=1 and `dec_code`=000.
- R6: If no enabled trap hits and the tag differs, configuration bit 7 picks the port: 0 gives port 1 and 1 gives port 2.
- R7: `dec_code` is one-hot: bit 0 is extract, bit 1 is port 1, bit 2 is port 2. `dec_vld` is high for exactly one cycle per frame, in the cycle after byte 14 is accepted. `dec_code` and `dec_tagged` are 0 whenever `dec_vld` is 0.
- R8: A configuration write with bit 6 set raises `xfifo_rst` for exactly one cycle, the cycle after the write. The stored bit then clears itself.
- R9: A frame whose last byte (`byte_eof`) arrives at or before byte 13 produces no strobe. It adds 1 to `runt_cnt`, which saturates at its maximum.
- R10: `byte_sof` restarts the byte count at byte 1, even in the middle of a frame, and the unfinished frame counts as no runt. Bytes after byte 14 are ignored until the next `byte_sof`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word (bits 9, 8, 7, 6 used) |
| tag_id | input | 16 | Tag protocol identifier compared with bytes 13 and 14 |
| byte_vld | input | 1 | Frame byte valid |
| byte_sof | input | 1 | Marks byte 1 of a frame, qualified by byte_vld |
| byte_eof | input | 1 | Marks the last byte of a frame, qualified by byte_vld |
| byte_data | input | 8 | Frame byte |
| dec_vld | output | 1 | Decision strobe |
| dec_code | output | 3 | One-hot decision: bit 0 extract, bit 1 port 1, bit 2 port 2 |
| dec_tagged | output | 1 | Frame carries the programmed tag, for external VLAN forwarding |
| xfifo_rst | output | 1 | Single-cycle extract FIFO reset |
| runt_cnt | output | 8 | Saturating count of frames that ended before byte 14 |

## Verification
The assertions assume that `byte_sof` and `byte_eof` are only high together with `byte_vld`. They also assume that `tag_id` and the configuration stay constant while a frame's header bytes are arriving, so that the decision reflects one consistent setting. The stimulus writes the configuration and the tag identifier only between frames. It raises the frame markers only on valid bytes. It mixes random configuration words, near-miss management prefixes, broadcast and random addresses, and matching and non-matching tags. Directed cases cover runts, aborted frames restarted by a new start marker, and frames longer than the header.

// File: rtl/trap_pkg.sv
package trap_pkg;
   typedef logic [2:0] dec_code_t;
   localparam dec_code_t DEC_NONE    = 3'b000;
   localparam dec_code_t DEC_EXTRACT = 3'b001;
   localparam dec_code_t DEC_PORT1   = 3'b010;
   localparam dec_code_t DEC_PORT2   = 3'b100;
   localparam logic [23:0] MGMT_PREFIX = 24'h0180C2;
   localparam int PREFIX_BYTES = 3;
endpackage

// File: rtl/tc_cfg_reg.sv
module tc_cfg_reg #(
   parameter int CFG_W   = 16,
   parameter int B_MGMT  = 9,
   parameter int B_BCAST = 8,
   parameter int B_NOTAG = 7,
   parameter int B_FRST  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic             en_mgmt,
   output logic             en_bcast,
   output logic             notag_sel,
   output logic             fifo_rst
);
   logic unused_cfg_bits;
   assign unused_cfg_bits = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_mgmt   <= 1'b0;
         en_bcast  <= 1'b0;
         notag_sel <= 1'b0;
         fifo_rst  <= 1'b0;
      end else if (we) begin
         en_mgmt   <= wdata[B_MGMT];
         en_bcast  <= wdata[B_BCAST];
         notag_sel <= wdata[B_NOTAG];
         fifo_rst  <= wdata[B_FRST];
      end else begin
         fifo_rst  <= 1'b0;
      end
   end

   // R8
   fifo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rst && !(we && wdata[B_FRST]) |=> !fifo_rst);
   // R8
   fifo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_rst) |-> $past(we));
endmodule

// File: rtl/tc_byte_ctr.sv
module tc_byte_ctr #(
   parameter int LAST   = 14,
   parameter int RUNT_W = 8,
   parameter bit RUNT_SAT = 1'b1,
   localparam int CNT_W = $clog2(LAST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic              byte_sof,
   input  logic              byte_eof,
   output logic              take,
   output logic [CNT_W-1:0]  pos,
   output logic              last,
   output logic [RUNT_W-1:0] runt_cnt
);
   logic [CNT_W-1:0] cnt;
   logic             active;
   logic             runt_inc;

   assign take     = byte_vld && (byte_sof || (active && cnt < CNT_W'(LAST)));
   assign pos      = byte_sof ? CNT_W'(1) : CNT_W'(cnt + 1'b1);
   assign last     = take && pos == CNT_W'(LAST);
   assign runt_inc = take && byte_eof && pos < CNT_W'(LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (take) begin
         cnt    <= pos;
         active <= !byte_eof;
      end else if (byte_vld && byte_eof) begin
         active <= 1'b0;
      end
   end

   generate
      if (RUNT_SAT) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)                     runt_cnt <= '0;
            else if (runt_inc && !(&runt_cnt)) runt_cnt <= runt_cnt + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)        runt_cnt <= '0;
            else if (runt_inc) runt_cnt <= runt_cnt + 1'b1;
         end
      end
   endgenerate

   // R10
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(LAST));
   // R9
   runt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_vld && byte_eof) |=> $stable(runt_cnt));
endmodule

// File: rtl/tc_field_match.sv
module tc_field_match
   import trap_pkg::*;
#(
   parameter int DW         = 8,
   parameter int ADDR_BYTES = 6,
   parameter int TAG_HI     = 13,
   parameter int CNT_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [CNT_W-1:0] pos,
   input  logic [DW-1:0]    data,
   output logic             mgmt_hit,
   output logic             bcast_hit,
   output logic [DW-1:0]    tag_hi
);
   logic [ADDR_BYTES-1:0] at_pos;
   logic [ADDR_BYTES-1:0] m_cmp;
   logic                  in_da, first, m_ok, b_ok;

   for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_da
      assign at_pos[k] = pos == CNT_W'(k + 1);
      if (k < PREFIX_BYTES) begin : g_pfx
         assign m_cmp[k] = data == MGMT_PREFIX[(PREFIX_BYTES-1-k)*8 +: 8];
      end else begin : g_any
         assign m_cmp[k] = 1'b1;
      end
   end

   assign in_da = |at_pos;
   assign first = at_pos[0];
   assign m_ok  = |(at_pos & m_cmp);
   assign b_ok  = &data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mgmt_hit  <= 1'b0;
         bcast_hit <= 1'b0;
         tag_hi    <= '0;
      end else if (take) begin
         if (in_da) begin
            mgmt_hit  <= (first || mgmt_hit) && m_ok;
            bcast_hit <= (first || bcast_hit) && b_ok;
         end
         if (pos == CNT_W'(TAG_HI)) tag_hi <= data;
      end
   end
endmodule

// File: rtl/tc_decide.sv
module tc_decide
   import trap_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            last,
   input  logic            en_mgmt,
   input  logic            en_bcast,
   input  logic            notag_sel,
   input  logic            mgmt_hit,
   input  logic            bcast_hit,
   input  logic [DW-1:0]   tag_hi,
   input  logic [DW-1:0]   tag_lo,
   input  logic [2*DW-1:0] tag_id,
   output logic            dec_vld,
   output dec_code_t       dec_code,
   output logic            dec_tagged
);
   logic extract, tag_eq;
   assign extract = (en_mgmt && mgmt_hit) || (en_bcast && bcast_hit);
   assign tag_eq  = {tag_hi, tag_lo} == tag_id;

   always_ff @(posedge clk) begin
      if (!rst_n || !last) begin
         dec_vld    <= 1'b0;
         dec_code   <= DEC_NONE;
         dec_tagged <= 1'b0;
      end else begin
         dec_vld    <= 1'b1;
         dec_tagged <= !extract && tag_eq;
         if (extract)     dec_code <= DEC_EXTRACT;
         else if (tag_eq) dec_code <= DEC_NONE;
         else             dec_code <= notag_sel ? DEC_PORT2 : DEC_PORT1;
      end
   end

   // R7
   code_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dec_code));
   // R7
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |=> !dec_vld);
   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_vld |-> (dec_code == DEC_NONE && !dec_tagged));
   // R5
   tagged_noport_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_tagged |-> dec_code == DEC_NONE);
   // R4
   extract_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (dec_code[0] |-> ($past(en_mgmt) || $past(en_bcast))));
endmodule

// File: rtl/eth_trap_classifier.sv
module eth_trap_classifier
   import trap_pkg::*;
#(
   parameter int DW         = 8,
   parameter int ADDR_BYTES = 6,
   parameter int CFG_W      = 16,
   parameter int B_MGMT     = 9,
   parameter int B_BCAST    = 8,
   parameter int B_NOTAG    = 7,
   parameter int B_FRST     = 6,
   parameter int RUNT_W     = 8,
   parameter bit RUNT_SAT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic [2*DW-1:0]   tag_id,
   input  logic              byte_vld,
   input  logic              byte_sof,
   input  logic              byte_eof,
   input  logic [DW-1:0]     byte_data,
   output logic              dec_vld,
   output logic [2:0]        dec_code,
   output logic              dec_tagged,
   output logic              xfifo_rst,
   output logic [RUNT_W-1:0] runt_cnt
);
   localparam int TAG_HI = 2 * ADDR_BYTES + 1;
   localparam int LAST   = TAG_HI + 1;
   localparam int CNT_W  = $clog2(LAST + 1);

   if (DW != 8) begin : g_bad_dw
      $error("eth_trap_classifier: byte width must be 8");
   end
   if (ADDR_BYTES < PREFIX_BYTES) begin : g_bad_addr
      $error("eth_trap_classifier: address shorter than management prefix");
   end
   if (B_MGMT >= CFG_W || B_BCAST >= CFG_W || B_NOTAG >= CFG_W || B_FRST >= CFG_W) begin : g_bad_bits
      $error("eth_trap_classifier: configuration bit outside word");
   end
   if (RUNT_W < 1) begin : g_bad_runt
      $error("eth_trap_classifier: runt counter width must be positive");
   end

   logic             en_mgmt, en_bcast, notag_sel;
   logic             take, last, mgmt_hit, bcast_hit;
   logic [CNT_W-1:0] pos;
   logic [DW-1:0]    tag_hi;
   dec_code_t        code_q;

   tc_cfg_reg #(.CFG_W(CFG_W), .B_MGMT(B_MGMT), .B_BCAST(B_BCAST),
                .B_NOTAG(B_NOTAG), .B_FRST(B_FRST)) u_cfg (
      .clk, .rst_n, .we(cfg_we), .wdata(cfg_wdata),
      .en_mgmt, .en_bcast, .notag_sel, .fifo_rst(xfifo_rst));

   tc_byte_ctr #(.LAST(LAST), .RUNT_W(RUNT_W), .RUNT_SAT(RUNT_SAT)) u_ctr (
      .clk, .rst_n, .byte_vld, .byte_sof, .byte_eof,
      .take, .pos, .last, .runt_cnt);

   tc_field_match #(.DW(DW), .ADDR_BYTES(ADDR_BYTES), .TAG_HI(TAG_HI),
                    .CNT_W(CNT_W)) u_match (
      .clk, .rst_n, .take, .pos, .data(byte_data),
      .mgmt_hit, .bcast_hit, .tag_hi);

   tc_decide #(.DW(DW)) u_dec (
      .clk, .rst_n, .last, .en_mgmt, .en_bcast, .notag_sel,
      .mgmt_hit, .bcast_hit, .tag_hi, .tag_lo(byte_data), .tag_id,
      .dec_vld, .dec_code(code_q), .dec_tagged);

   assign dec_code = code_q;

   // R9
   runt_nostrobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && byte_eof && !last) |=> !dec_vld);
endmodule

// File: tb/eth_trap_classifier_bench.sv
module eth_trap_classifier_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] tag_id = 16'h8100;
   logic        byte_vld = 1'b0, byte_sof = 1'b0, byte_eof = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        dec_vld, dec_tagged, xfifo_rst;
   logic [2:0]  dec_code;
   logic [7:0]  runt_cnt;

   int checks = 0, errors = 0;
   int n_dec = 0;
   logic [2:0]  got_code;
   logic        got_tag;
   logic [15:0] cfg_now = '0;
   logic [7:0]  fr [0:31];
   bit          finished = 1'b0;

   always #5 clk = ~clk;

   eth_trap_classifier u_eth_trap_classifier (
      .clk, .rst_n, .cfg_we, .cfg_wdata, .tag_id, .byte_vld, .byte_sof,
      .byte_eof, .byte_data, .dec_vld, .dec_code, .dec_tagged, .xfifo_rst,
      .runt_cnt);

   always @(posedge clk) begin
      #2;
      if (dec_vld) begin
         n_dec    = n_dec + 1;
         got_code = dec_code;
         got_tag  = dec_tagged;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] expect_dec();
      bit m, b, ext;
      m   = fr[0] == 8'h01 && fr[1] == 8'h80 && fr[2] == 8'hC2;
      b   = fr[0] == 8'hFF && fr[1] == 8'hFF && fr[2] == 8'hFF &&
            fr[3] == 8'hFF && fr[4] == 8'hFF && fr[5] == 8'hFF;
      ext = (cfg_now[9] && m) || (cfg_now[8] && b);
      if (ext) return 4'b0001;
      if ({fr[12], fr[13]} == tag_id) return 4'b1000;
      return cfg_now[7] ? 4'b0100 : 4'b0010;
   endfunction

   task automatic write_cfg(input logic [15:0] w);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = w;
      @(negedge clk);
      cfg_we = 1'b0;
      cfg_now = w;
      check(xfifo_rst == w[6], "R8 pulse", xfifo_rst, w[6]);
      @(negedge clk);
      check(xfifo_rst == 1'b0, "R8 self-clear", xfifo_rst, 0);
   endtask

   task automatic send(input int len, input bit with_eof);
      n_dec = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         byte_vld = 1'b1; byte_sof = (i == 0);
         byte_eof = with_eof && (i == len - 1);
         byte_data = fr[i];
      end
      @(negedge clk);
      byte_vld = 1'b0; byte_sof = 1'b0; byte_eof = 1'b0;
      @(negedge clk);
   endtask

   task automatic fill(input int da_kind, input bit tag_match);
      for (int i = 0; i < 32; i++) fr[i] = 8'($urandom);
      case (da_kind)
         0: begin fr[0] = 8'h01; fr[1] = 8'h80; fr[2] = 8'hC2; end
         1: for (int i = 0; i < 6; i++) fr[i] = 8'hFF;
         3: begin fr[0] = 8'h01; fr[1] = 8'h80; fr[2] = 8'hC3; end
         default: ;
      endcase
      if (tag_match) begin fr[12] = tag_id[15:8]; fr[13] = tag_id[7:0]; end
   endtask

   task automatic frame_check(input int len, input string req);
      logic [3:0] e;
      e = expect_dec();
      send(len, 1'b1);
      check(n_dec == 1, {req, " R7 strobe count"}, n_dec, 1);
      check(got_code == e[2:0], {req, " code"}, got_code, e[2:0]);
      check(got_tag == e[3], {req, " R5 tagged"}, got_tag, e[3]);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] r0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 reset state
      check(dec_vld == 0 && xfifo_rst == 0, "R3 outputs", {dec_vld, xfifo_rst}, 0);
      check(runt_cnt == 0, "R3 runt", runt_cnt, 0);
      // R3 traps disabled after reset: management frame goes to a port
      fill(0, 1'b0);
      frame_check(14, "R3 no trap");
      // R1 management trap, tail bytes differ
      write_cfg(16'h0200);
      fill(0, 1'b0); fr[3] = 8'h00; fr[4] = 8'h55; fr[5] = 8'hAA;
      frame_check(14, "R1 mgmt");
      fill(3, 1'b0);
      frame_check(14, "R1 near miss");
      // R2 broadcast trap
      write_cfg(16'h0100);
      fill(1, 1'b0);
      frame_check(15, "R2 bcast");
      // R4 precedence over tag and port bit
      write_cfg(16'h0380);
      fill(1, 1'b1);
      frame_check(14, "R4 precedence");
      // R6 port steering
      write_cfg(16'h0080);
      fill(2, 1'b0);
      frame_check(14, "R6 port2");
      write_cfg(16'h0000);
      fill(2, 1'b0);
      frame_check(14, "R6 port1");
      // R8 fifo reset pulse
      write_cfg(16'h0040);
      // R9 runt
      r0 = runt_cnt;
      fill(2, 1'b0);
      send(13, 1'b1);
      check(n_dec == 0, "R9 no strobe", n_dec, 0);
      check(runt_cnt == r0 + 1, "R9 runt count", runt_cnt, r0 + 1);
      // R10 aborted frame restarted by start marker
      r0 = runt_cnt;
      fill(2, 1'b0);
      send(7, 1'b0);
      check(n_dec == 0, "R10 aborted", n_dec, 0);
      fill(0, 1'b1);
      write_cfg(16'h0000);
      frame_check(20, "R10 restart");
      check(runt_cnt == r0, "R10 no runt", runt_cnt, r0);
      // R10 bytes after 14 ignored: eof past header is no runt
      tag_id = 16'h88A8;
      fill(2, 1'b1);
      frame_check(24, "R10 long tagged");
      // random mix
      for (int it = 0; it < 200; it++) begin
         logic [15:0] w;
         w = 16'($urandom) & 16'h03C0;
         write_cfg(w);
         if (it % 50 == 0) tag_id = 16'($urandom);
         fill(int'($urandom % 4), 1'($urandom));
         frame_check(14 + int'($urandom % 6), "R4 random");
      end
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule